// File: doc/BRIEF.md
# Byte-Granular Load/Store Adapter

This block connects a processor load/store port that issues byte addresses to a memory that stores only whole 32-bit words. For every request it clears the two low address bits to form the word address. It then uses those two bits as a byte offset. On a load, the offset picks the requested byte or halfword out of the fetched word and places it at the low end of the result. On a store, the offset steers the low-order bytes of the store data onto the correct byte lanes and enables only those lanes.

The request and response sides are valid/ready streams. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. A response must be taken before another request can enter, so `req_ready` is low while a response is waiting and `rsp_ready` is low. Once raised, `rsp_valid` stays high, and its data and error flag do not change, until the edge where `rsp_ready` is high. The memory has a one-cycle synchronous read. Its read data is only valid in the cycle after the read, so the adapter keeps a copy of the aligned result while the response is stalled.

Sizes are encoded on `req_size` as 00 for a byte, 01 for a halfword, 10 for a word and 11 for an illegal size.

Top module: `byte_lsu_adapter`

## Requirements
- R1: An accepted, legal request drives `mem_req` high in the same cycle, with `mem_addr` equal to `req_addr[31:2]`. `mem_req` is never high without an accepted request.
- R2: A byte load (size 00) returns, in `rsp_rdata[7:0]`, the byte on lane `req_addr[1:0]` of the fetched word, where lane n is bits 8n+7:8n (little-endian).
- R3: A halfword load (size 01) at offset 0 or 2 returns lanes {offset+1, offset} in `rsp_rdata[15:0]`. A word load returns the whole word unchanged.
- R4: When `req_signed` is 0, the unused upper bits of a byte or halfword load result are zero. When it is 1, they copy the top bit of the loaded byte or halfword. A word load ignores `req_signed`.
- R5: A byte store raises only `mem_be` bit `req_addr[1:0]`, and that lane carries `req_wdata[7:0]`. The other three bytes of the memory word stay unchanged.
- R6: A halfword store raises `mem_be` 0011 at offset 0 and 1100 at offset 2, with `req_wdata[15:0]` on those two lanes.
- R7: A word store raises all four `mem_be` bits and writes `req_wdata` unchanged.
- R8: A halfword request with `req_addr[0]` set, a word request with either low address bit set, and any size 11 request all cause the following response to have `rsp_err` high and `rsp_rdata` zero. The request makes no memory access, and memory stays unchanged.
- R9: `rsp_valid` is high in the cycle after every accepted request. Loads return the aligned data in that cycle. Stores respond with `rsp_rdata` zero and `rsp_err` low.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low, no memory access is made, and `rsp_valid`, `rsp_rdata` and `rsp_err` hold steady. This holds even when the memory read data changes during the stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 32 | Byte address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 illegal |
| req_signed | input | 1 | Sign-extend byte/halfword loads |
| req_wdata | input | 32 | Store data, low-order aligned |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Aligned, extended load result |
| rsp_err | output | 1 | Misaligned or illegal-size request |
| mem_req | output | 1 | Memory access strobe |
| mem_addr | output | 30 | Word address |
| mem_we | output | 1 | Memory write |
| mem_be | output | 4 | Per-byte write enables |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |

## Verification
On every cycle, the assertions check the byte-enable shape for each store size, that a misaligned request never reaches memory and always answers with an error, the one-cycle response latency, and the stall rules on both streams. Which lane a byte lands in, the extended load values, and whether neighbouring bytes survive a narrow store depend on memory contents. Only the bench's sweeps over sizes, offsets and sign modes show these, using a shadow byte image of the memory and a memory model that scrambles its output on idle cycles.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_BAD  = 2'b11
  } acc_size_e;
endpackage

// File: rtl/lsu_align_check.sv
module lsu_align_check
  import lsu_pkg::*;
#(
  parameter int unsigned OFS_W = 2
) (
  input  acc_size_e        size,
  input  logic [OFS_W-1:0] ofs,
  output logic             misaligned
);
  always_comb begin
    case (size)
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = ofs[0];
      SZ_WORD: misaligned = |ofs;
      default: misaligned = 1'b1;
    endcase
  end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NB     = DATA_W / 8,
  parameter int unsigned OFS_W  = $clog2(NB)
) (
  input  acc_size_e         size,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] src,
  output logic [NB-1:0]     lane_en,
  output logic [DATA_W-1:0] lane_data
);
  for (genvar i = 0; i < NB; i++) begin : g_lane
    localparam int unsigned HALF_IDX = i / 2;
    localparam int unsigned IN_HALF  = i % 2;
    always_comb begin
      case (size)
        SZ_BYTE: begin
          lane_en[i]        = (ofs == OFS_W'(i));
          lane_data[i*8+:8] = src[7:0];
        end
        SZ_HALF: begin
          lane_en[i]        = (ofs[OFS_W-1:1] == (OFS_W-1)'(HALF_IDX));
          lane_data[i*8+:8] = src[IN_HALF*8+:8];
        end
        SZ_WORD: begin
          lane_en[i]        = 1'b1;
          lane_data[i*8+:8] = src[i*8+:8];
        end
        default: begin
          lane_en[i]        = 1'b0;
          lane_data[i*8+:8] = 8'h00;
        end
      endcase
    end
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NB     = DATA_W / 8,
  parameter int unsigned OFS_W  = $clog2(NB)
) (
  input  acc_size_e         size,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              sign_ext,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] shifted;
  logic [7:0]        sel_b;
  logic [15:0]       sel_h;

  assign shifted = word >> {ofs, 3'b000};
  assign sel_b   = shifted[7:0];
  assign sel_h   = shifted[15:0];

  always_comb begin
    case (size)
      SZ_BYTE: result = {{(DATA_W-8){sign_ext & sel_b[7]}}, sel_b};
      SZ_HALF: result = {{(DATA_W-16){sign_ext & sel_h[15]}}, sel_h};
      default: result = word;
    endcase
  end
endmodule

// File: rtl/byte_lsu_adapter.sv
module byte_lsu_adapter
  import lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WA_W   = ADDR_W - $clog2(DATA_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              mem_req,
  output logic [WA_W-1:0]   mem_addr,
  output logic              mem_we,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int unsigned NB    = DATA_W / 8;
  localparam int unsigned OFS_W = $clog2(NB);

  acc_size_e         size_in;
  logic [OFS_W-1:0]  ofs_in;
  logic              bad_in;
  logic              accept;

  logic              pend_q;
  logic              live_q;
  logic              wr_q;
  logic              err_q;
  logic              sgn_q;
  acc_size_e         size_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] aligned;

  assign size_in = acc_size_e'(req_size);
  assign ofs_in  = req_addr[OFS_W-1:0];

  lsu_align_check #(.OFS_W(OFS_W)) u_align (
    .size       (size_in),
    .ofs        (ofs_in),
    .misaligned (bad_in)
  );

  lsu_store_lanes #(.DATA_W(DATA_W)) u_lanes (
    .size      (size_in),
    .ofs       (ofs_in),
    .src       (req_wdata),
    .lane_en   (mem_be),
    .lane_data (mem_wdata)
  );

  lsu_load_extract #(.DATA_W(DATA_W)) u_extract (
    .size     (size_q),
    .ofs      (ofs_q),
    .sign_ext (sgn_q),
    .word     (mem_rdata),
    .result   (aligned)
  );

  assign req_ready = !pend_q || rsp_ready;
  assign accept    = req_valid && req_ready;

  assign mem_req   = accept && !bad_in;
  assign mem_addr  = req_addr[ADDR_W-1:OFS_W];
  assign mem_we    = req_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      live_q <= 1'b0;
      wr_q   <= 1'b0;
      err_q  <= 1'b0;
      sgn_q  <= 1'b0;
      size_q <= SZ_BYTE;
      ofs_q  <= '0;
      hold_q <= '0;
    end else if (accept) begin
      pend_q <= 1'b1;
      live_q <= 1'b1;
      wr_q   <= req_write;
      err_q  <= bad_in;
      sgn_q  <= req_signed;
      size_q <= size_in;
      ofs_q  <= ofs_in;
    end else if (pend_q && rsp_ready) begin
      pend_q <= 1'b0;
      live_q <= 1'b0;
    end else if (pend_q && live_q) begin
      hold_q <= aligned;
      live_q <= 1'b0;
    end
  end

  assign rsp_valid = pend_q;
  assign rsp_err   = pend_q && err_q;

  always_comb begin
    if (!pend_q || wr_q || err_q) rsp_rdata = '0;
    else if (live_q)              rsp_rdata = aligned;
    else                          rsp_rdata = hold_q;
  end
endmodule

// File: rtl/lsu_adapter_checker.sv
module lsu_adapter_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WA_W   = ADDR_W - $clog2(DATA_W / 8)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_write,
  input logic [1:0]        req_size,
  input logic              req_signed,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_err,
  input logic              mem_req,
  input logic [WA_W-1:0]   mem_addr,
  input logic              mem_we,
  input logic [DATA_W/8-1:0] mem_be,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [DATA_W-1:0] mem_rdata
);
  localparam int unsigned OFS_W = $clog2(DATA_W / 8);

  logic fire;
  logic illegal;
  assign fire    = req_valid && req_ready;
  assign illegal = (req_size == 2'b11)
                || (req_size == 2'b01 && req_addr[0])
                || (req_size == 2'b10 && (|req_addr[OFS_W-1:0]));

  p_mem_only_on_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (req_valid && req_ready));

  p_byte_store_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && req_size == 2'b00) |->
      ($countones(mem_be) == 1 && mem_be[req_addr[OFS_W-1:0]]));

  p_half_store_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && req_size == 2'b01) |->
      ($countones(mem_be) == 2 && mem_be[req_addr[OFS_W-1:0]]));

  p_word_store_lanes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && req_size == 2'b10) |-> (&mem_be));

  p_no_mem_on_misalign_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && illegal) |-> !mem_req);

  p_err_response_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && illegal) |=> (rsp_valid && rsp_err && rsp_rdata == '0));

  p_resp_next_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid);

  p_stall_blocks_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> (!req_ready && !mem_req));

  p_stall_holds_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));
endmodule

bind byte_lsu_adapter lsu_adapter_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/sim_byte_lsu_adapter.sv
module sim_byte_lsu_adapter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic        req_signed = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic        mem_req;
  logic [29:0] mem_addr;
  logic        mem_we;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;

  int checks = 0;
  int errors = 0;
  logic [7:0]  sh [0:63];
  logic [31:0] ram [0:15];

  always #10 clk = ~clk;

  byte_lsu_adapter u0 (.*);

  function automatic logic [7:0] pat(input int k);
    return 8'(k * 37 + 11);
  endfunction

  // memory model: one-cycle read, output scrambled on idle cycles
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 16; k++)
        ram[k] <= {pat(4*k+3), pat(4*k+2), pat(4*k+1), pat(4*k)};
      mem_rdata <= '0;
    end else if (mem_req) begin
      if (mem_we)
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) ram[mem_addr[3:0]][b*8+:8] <= mem_wdata[b*8+:8];
      mem_rdata <= ram[mem_addr[3:0]];
    end else begin
      mem_rdata <= ~mem_rdata ^ 32'h5A5A_0F0F;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] addr_of(input logic [3:0] w, input logic [1:0] o);
    return {26'h2A5_3C1 ^ 26'({w, w, w}), w, o};
  endfunction

  task automatic op(input logic [3:0] w, input logic [1:0] o, input logic [1:0] sz,
                    input logic sg, input logic wr, input logic [31:0] wd);
    logic        bad;
    logic [3:0]  be;
    logic [31:0] exp;
    logic [31:0] a;
    int          base;
    base = 4 * w;
    a    = addr_of(w, o);
    bad  = (sz == 2'b11) || (sz == 2'b01 && o[0]) || (sz == 2'b10 && o != 2'b00);
    case (sz)
      2'b00:   be = 4'b0001 << o;
      2'b01:   be = 4'b0011 << o;
      default: be = 4'b1111;
    endcase
    exp = '0;
    if (!wr && !bad) begin
      case (sz)
        2'b00: exp = {{24{sg & sh[base+o][7]}}, sh[base+o]};
        2'b01: exp = {{16{sg & sh[base+o+1][7]}}, sh[base+o+1], sh[base+o]};
        default: exp = {sh[base+3], sh[base+2], sh[base+1], sh[base]};
      endcase
    end
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_size = sz;
    req_signed = sg; req_wdata = wd;
    #1;
    chk(mem_req == !bad, "R1/R8 mem_req", 32'(mem_req), 32'(!bad));
    if (!bad) begin
      chk(mem_addr == a[31:2], "R1 word address", 32'(mem_addr), 32'(a[31:2]));
      if (wr) begin
        chk(mem_be == be, sz == 2'b00 ? "R5 byte enables" :
            sz == 2'b01 ? "R6 half enables" : "R7 word enables",
            32'(mem_be), 32'(be));
        for (int b = 0; b < 4; b++)
          if (be[b]) begin
            logic [7:0] eb;
            eb = wd[(b - int'(o)) * 8 +: 8];
            chk(mem_wdata[b*8+:8] == eb, "R5/R6/R7 lane data",
                32'(mem_wdata[b*8+:8]), 32'(eb));
          end
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(rsp_valid, "R9 response valid", 32'(rsp_valid), 32'd1);
    chk(rsp_err == bad, "R8 error flag", 32'(rsp_err), 32'(bad));
    chk(rsp_rdata == exp, wr ? "R9 store response data" :
        sz == 2'b00 ? "R2/R4 byte load" : "R3/R4 half/word load",
        rsp_rdata, exp);
    if (wr && !bad)
      for (int b = 0; b < 4; b++)
        if (be[b]) sh[base+b] = wd[(b - int'(o)) * 8 +: 8];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    for (int k = 0; k < 64; k++) sh[k] = pat(k);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!rsp_valid, "reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk(req_ready, "reset req_ready", 32'(req_ready), 32'd1);
    chk(!mem_req, "reset mem_req", 32'(mem_req), 32'd0);

    // loads on initial contents, all sizes, offsets, sign modes
    n = 0;
    for (int sz = 0; sz < 4; sz++)
      for (int o = 0; o < 4; o++)
        for (int sg = 0; sg < 2; sg++) begin
          op(4'(n), 2'(o), 2'(sz), 1'(sg), 1'b0, 32'h0);
          n++;
        end
    // stores of every size and offset (misaligned ones must not write)
    for (int sz = 0; sz < 4; sz++)
      for (int o = 0; o < 4; o++) begin
        op(4'(n), 2'(o), 2'(sz), 1'b0, 1'b1, 32'h9E37_79B9 * 32'(n + 1));
        n++;
      end
    // loads after stores: neighbours unchanged, extension modes
    for (int sz = 0; sz < 3; sz++)
      for (int o = 0; o < 4; o++)
        for (int sg = 0; sg < 2; sg++) begin
          op(4'(n), 2'(o), 2'(sz), 1'(sg), 1'b0, 32'h0);
          n++;
        end
    // R10: stalled response holds while memory output scrambles
    begin
      logic [31:0] e;
      op(4'd5, 2'd0, 2'b10, 1'b0, 1'b0, 32'h0);
      e = {{24{sh[21][7]}}, sh[21]};
      @(negedge clk);
      rsp_ready = 1'b0;
      req_valid = 1'b1; req_addr = addr_of(4'd5, 2'd1); req_write = 1'b0;
      req_size = 2'b00; req_signed = 1'b1;
      @(negedge clk);
      req_addr = addr_of(4'd5, 2'd0); req_write = 1'b1; req_size = 2'b10;
      req_wdata = 32'hFFFF_FFFF;
      for (int c = 0; c < 4; c++) begin
        #1;
        chk(rsp_valid, "R10 valid held", 32'(rsp_valid), 32'd1);
        chk(rsp_rdata == e, "R10 data held", rsp_rdata, e);
        chk(!req_ready, "R10 req_ready low", 32'(req_ready), 32'd0);
        chk(!mem_req, "R10 no mem access", 32'(mem_req), 32'd0);
        @(negedge clk);
      end
      req_valid = 1'b0;
      rsp_ready = 1'b1;
      @(negedge clk);
      #1;
      chk(!rsp_valid, "R10 response drained", 32'(rsp_valid), 32'd0);
    end
    // final readback of every word
    for (int w = 0; w < 16; w++) op(4'(w), 2'd0, 2'b10, 1'b0, 1'b0, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule